// File: doc/BRIEF.md
# Triggered One-Pulse Waveform Timer

An up-counting timer with a single compare channel. The counter sits at zero, stopped, until an edge on the external trigger input starts it. The output turns active once the counter has reached the compare value and returns inactive when the counter rolls over from the reload value to zero. The compare value therefore sets the delay and the gap between compare and reload sets the pulse width. A prescaler stretches every count to (PSC+1) clock cycles.

Software programs the block through a simple write port with four addresses: 0 compare, 1 reload, 2 prescaler and 3 control. The control word holds the following bits. Bit 0 selects single-shot operation. Bit 1 enables shadow registers for the compare and reload values. Bit 2 enables the fast path. Bits 4:3 select the output mode: 00 frozen, 01 PWM1, 10 PWM2 and 11 frozen. Bit 5 inverts the output polarity. Bit 6 makes the trigger act on falling edges instead of rising edges. Writing control with bit 7 set also raises a software update event, and bit 7 is not stored. With single-shot clear the waveform repeats every period. With the fast path the output is forced from the trigger edge itself.

Top module: `opm_timer`

## Requirements
- R1: After reset the counter is stopped, `pulse_out` is 0 and `update_evt` is 0.
- R2: The trigger edge chosen by control bit 6 (0 = rising, 1 = falling) starts the counter. The opposite edge on `trig_in` does not start the counter and leaves the output unchanged.
- R3: In PWM2 mode (bits 4:3 = 10) with the fast path off, the output goes active exactly (PSC+1)·CMP + 3 clock cycles after the trigger edge appears on `trig_in`.
- R4: In PWM2 mode the output stays active for (PSC+1)·(ARR−CMP+1) cycles.
- R5: In PWM1 mode (bits 4:3 = 01) the output is active from 3 cycles after the trigger edge until the compare match, which is (PSC+1)·CMP cycles. In frozen modes (00 and 11) the output never leaves its inactive level.
- R6: With single-shot set (bit 0 = 1), the counter stops at the rollover, holds 0 and leaves the output inactive. No second pulse follows.
- R7: With single-shot clear, the pulse repeats with a period of (PSC+1)·(ARR+1) cycles. Setting single-shot while the counter runs stops it at the next rollover.
- R8: `update_evt` is high for one cycle after each rollover and after each control write that has bit 7 set. At a PWM2 rollover it is seen one cycle before the output falls.
- R9: With shadowing on (bit 1 = 1), writes to address 0 or 1 take effect only at the next update event. With shadowing off they take effect at once.
- R10: With the fast path (bit 2 = 1) in PWM2 mode, the output goes active 2 cycles after the trigger edge and stays active for 1+(PSC+1)·(ARR+1) cycles. In a frozen mode the fast bit has no effect.
- R11: With bit 5 = 1 the output is inverted, so it rests at 1 and the pulse is low-going.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare, 1 reload, 2 prescaler, 3 control |
| wr_data | input | DW | Write data |
| trig_in | input | 1 | External trigger, asynchronous |
| pulse_out | output | 1 | Waveform output |
| update_evt | output | 1 | One-cycle update-event flag |

## Verification
Every internal fault in this block shows up as a shifted or missing edge on `pulse_out` or `update_evt`. The bench measures the count of clock edges between the trigger and the output edges, so an off-by-one in the synchroniser, the prescaler or the compare shows as a wrong delay or width within the first period. A start or stop bit that is stuck shows within one period as a pulse that is missing, repeats or never ends. A shadow register that loads at the wrong time shows on the next trigger as a delay taken from the wrong compare value.

// File: rtl/opm_pkg.sv
`timescale 1ns/1ps
package opm_pkg;

    typedef enum logic [1:0] {
        OC_FROZEN = 2'b00,
        OC_PWM1   = 2'b01,
        OC_PWM2   = 2'b10,
        OC_HOLD   = 2'b11
    } oc_mode_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic     edge_fall;  // bit 6
        logic     pol;        // bit 5
        oc_mode_e mode;       // bits 4:3
        logic     fast;       // bit 2
        logic     preload;    // bit 1
        logic     single;     // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int UG_BIT = 7;

    localparam logic [1:0] A_CMP  = 2'd0;
    localparam logic [1:0] A_ARR  = 2'd1;
    localparam logic [1:0] A_PSC  = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    function automatic logic is_pwm(oc_mode_e m);
        return (m == OC_PWM1) || (m == OC_PWM2);
    endfunction

endpackage

// File: rtl/opm_trig_sync.sv
`timescale 1ns/1ps
module opm_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic edge_fall,
    output logic start
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[LAST-1:0], trig_in};
    end

    logic now_lvl, old_lvl;
    assign now_lvl = sh[LAST-1];
    assign old_lvl = sh[LAST];

    always_comb begin
        if (edge_fall) start = !now_lvl && old_lvl;
        else           start = now_lvl && !old_lvl;
    end
endmodule

// File: rtl/opm_count_core.sv
`timescale 1ns/1ps
module opm_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         ug,
    input  logic         single,
    input  logic [W-1:0] psc,
    input  logic [W-1:0] arr,
    output logic         cen,
    output logic [W-1:0] cnt,
    output logic         roll,
    output logic         uev
);
    logic [W-1:0] pc;
    logic tick, at_top;

    assign tick   = (pc == psc);
    assign at_top = (cnt == arr);
    assign roll   = cen && tick && at_top && !ug;
    assign uev    = roll || ug;

    always_ff @(posedge clk) begin
        if (rst) begin
            cen <= 1'b0;
            cnt <= '0;
            pc  <= '0;
        end else if (ug) begin
            cnt <= '0;
            pc  <= '0;
        end else if (start && !cen) begin
            cen <= 1'b1;
            cnt <= '0;
            pc  <= '0;
        end else if (cen) begin
            if (tick) begin
                pc <= '0;
                if (at_top) begin
                    cnt <= '0;
                    if (single) cen <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    // R6
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        roll && single |=> !cen && cnt == '0);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        start && !cen && !ug |=> cen && cnt == '0);
    // R7
    repeat_chk: assert property (@(posedge clk) disable iff (rst)
        roll && !single |=> cen);
    // R1
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cen && !start && !ug |=> !cen && $stable(cnt));
endmodule

// File: rtl/opm_oc_channel.sv
`timescale 1ns/1ps
module opm_oc_channel
    import opm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cen,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  oc_mode_e     mode,
    input  logic         fast,
    input  logic         pol,
    input  logic         start,
    input  logic         period_end,
    output logic         pulse_out
);
    logic fast_ok, force_now, forced, match, oc_ref;

    assign fast_ok   = fast && is_pwm(mode);
    assign force_now = forced || (start && !cen && fast_ok);
    assign match     = (cnt >= cmp);

    always_ff @(posedge clk) begin
        if (rst)                            forced <= 1'b0;
        else if (period_end)                forced <= 1'b0;
        else if (start && !cen && fast_ok)  forced <= 1'b1;
    end

    always_comb begin
        unique case (mode)
            OC_PWM1: oc_ref = cen && !match && !force_now;
            OC_PWM2: oc_ref = (cen && match) || force_now;
            default: oc_ref = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_out <= 1'b0;
        else     pulse_out <= oc_ref ^ pol;
    end

    // R11
    rest_chk: assert property (@(posedge clk) disable iff (rst)
        !cen && !force_now |=> pulse_out == $past(pol));
    // R10
    fast_chk: assert property (@(posedge clk) disable iff (rst)
        start && !cen && fast && mode == OC_PWM2 |=> pulse_out == !$past(pol));
    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_FROZEN || mode == OC_HOLD) |=> pulse_out == $past(pol));
endmodule

// File: rtl/opm_timer.sv
`timescale 1ns/1ps
module opm_timer
    import opm_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          trig_in,
    output logic          pulse_out,
    output logic          update_evt
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] psc_q, cmp_pre, arr_pre, cmp_act, arr_act;
    logic          ug, start, cen, roll, uev;
    logic [DW-1:0] cnt;

    assign ug = wr_en && (wr_addr == A_CTRL) && wr_data[UG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            psc_q      <= '0;
            cmp_pre    <= '0;
            arr_pre    <= '0;
            cmp_act    <= '0;
            arr_act    <= '0;
            update_evt <= 1'b0;
        end else begin
            update_evt <= uev;
            if (wr_en) begin
                unique case (wr_addr)
                    A_CMP:   cmp_pre <= wr_data;
                    A_ARR:   arr_pre <= wr_data;
                    A_PSC:   psc_q   <= wr_data;
                    default: ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
                endcase
            end
            if (wr_en && wr_addr == A_CMP && !ctrl_q.preload) cmp_act <= wr_data;
            else if (uev)                                     cmp_act <= cmp_pre;
            if (wr_en && wr_addr == A_ARR && !ctrl_q.preload) arr_act <= wr_data;
            else if (uev)                                     arr_act <= arr_pre;
        end
    end

    opm_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .edge_fall(ctrl_q.edge_fall), .start(start)
    );

    opm_count_core #(.W(DW)) u_core (
        .clk(clk), .rst(rst), .start(start), .ug(ug),
        .single(ctrl_q.single), .psc(psc_q), .arr(arr_act),
        .cen(cen), .cnt(cnt), .roll(roll), .uev(uev)
    );

    opm_oc_channel #(.W(DW)) u_oc (
        .clk(clk), .rst(rst), .cen(cen), .cnt(cnt), .cmp(cmp_act),
        .mode(ctrl_q.mode), .fast(ctrl_q.fast), .pol(ctrl_q.pol),
        .start(start), .period_end(uev), .pulse_out(pulse_out)
    );

    // R9
    shadow_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.preload && !uev |=> $stable(cmp_act) && $stable(arr_act));
endmodule

// File: tb/tb_opm_timer.sv
`timescale 1ns/1ps
module tb_opm_timer;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          trig_in = 1'b0;
    logic          pulse_out, update_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    opm_timer #(.DW(DW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in),
        .pulse_out(pulse_out), .update_evt(update_evt)
    );

    // columns: psc, cmp, arr, mode, fast, delay, width, uev sample index (0 = skip)
    localparam int NV = 6;
    localparam int VEC [NV][8] = '{
        '{0, 2, 5, 2, 0, 5, 4, 3},   // R3 R4 base case
        '{1, 2, 5, 2, 0, 7, 8, 7},   // R3 R4 prescaler 2
        '{0, 0, 3, 2, 0, 3, 4, 3},   // R3 compare zero
        '{0, 3, 6, 2, 1, 2, 8, 7},   // R10 fast path
        '{0, 3, 6, 1, 0, 3, 3, 0},   // R5 PWM1
        '{2, 1, 2, 2, 0, 6, 6, 5}    // R4 prescaler 3
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[1:0];
        wr_data = d[DW-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // call right after changing trig_in at a negedge
    task automatic measure(input bit pol, output int d, output int w, output int uw);
        int n = 0;
        w = 0; uw = 0;
        do begin @(posedge clk); #1; n++; end while (!(pulse_out ^ pol) && n < 300);
        d = n - 1;
        do begin
            @(posedge clk); #1; w++;
            if (update_evt) uw = w;
        end while ((pulse_out ^ pol) && w < 300);
    endtask

    task automatic count_high(int cycles, output int hi, output int ue);
        hi = 0; ue = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (pulse_out) hi++;
            if (update_evt) ue++;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int d, w, uw, hi, ue;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pulse_out after reset", pulse_out, 0);
        chk("R1 update_evt after reset", update_evt, 0);
        count_high(6, hi, ue);
        chk("R1 no activity while stopped", hi + ue, 0);

        for (int r = 0; r < NV; r++) begin
            wr(3, 1 | (VEC[r][3] << 3) | (VEC[r][4] << 2));
            wr(2, VEC[r][0]);
            wr(0, VEC[r][1]);
            wr(1, VEC[r][2]);
            idle(2);
            @(negedge clk); trig_in = 1'b1;
            measure(1'b0, d, w, uw);
            chk($sformatf("R3 R10 delay row %0d", r), d, VEC[r][5]);
            chk($sformatf("R4 R5 R10 width row %0d", r), w, VEC[r][6]);
            chk($sformatf("R8 uev position row %0d", r), uw, VEC[r][7]);
            @(negedge clk); trig_in = 1'b0;
            count_high(15, hi, ue);
            chk($sformatf("R6 no second pulse row %0d", r), hi, 0);
        end

        // R2 falling edge selected: rising ignored, falling starts
        wr(3, 32'h51);
        wr(2, 0); wr(0, 1); wr(1, 3);
        idle(2);
        @(negedge clk); trig_in = 1'b1;
        count_high(12, hi, ue);
        chk("R2 rising edge ignored", hi + ue, 0);
        @(negedge clk); trig_in = 1'b0;
        measure(1'b0, d, w, uw);
        chk("R2 falling edge delay", d, 4);
        chk("R2 falling edge width", w, 3);
        idle(8);

        // R7 repetitive, then stop by setting single-shot
        wr(3, 32'h10);
        wr(0, 2); wr(1, 5);
        idle(2);
        @(negedge clk); trig_in = 1'b1;
        measure(1'b0, d, w, uw);
        chk("R7 first delay", d, 5);
        chk("R7 first width", w, 4);
        d = 0;
        do begin @(posedge clk); #1; d++; end while (!pulse_out && d < 300);
        chk("R7 gap before repeat", d, 2);
        @(negedge clk); trig_in = 1'b0;
        wr(3, 32'h11);
        idle(20);
        count_high(20, hi, ue);
        chk("R7 stops after single-shot set", hi + ue, 0);

        // R9 shadow registers, R8 software update
        wr(3, 32'h13);
        wr(0, 2); wr(1, 5);
        wr(3, 32'h93);
        chk("R8 update_evt after software update", update_evt, 1);
        @(negedge clk);
        chk("R8 update_evt lasts one cycle", update_evt, 0);
        wr(0, 4);
        idle(2);
        @(negedge clk); trig_in = 1'b1;
        measure(1'b0, d, w, uw);
        chk("R9 held compare delay", d, 5);
        chk("R9 held compare width", w, 4);
        @(negedge clk); trig_in = 1'b0;
        idle(8);
        @(negedge clk); trig_in = 1'b1;
        measure(1'b0, d, w, uw);
        chk("R9 loaded compare delay", d, 7);
        chk("R9 loaded compare width", w, 2);
        @(negedge clk); trig_in = 1'b0;
        idle(8);

        // R10 R5 fast bit in frozen mode has no effect
        wr(3, 32'h05);
        wr(0, 1); wr(1, 3);
        idle(2);
        @(negedge clk); trig_in = 1'b1;
        count_high(15, hi, ue);
        chk("R10 frozen mode output stays low", hi, 0);
        chk("R8 one rollover in frozen run", ue, 1);
        @(negedge clk); trig_in = 1'b0;
        idle(4);

        // R11 inverted polarity
        wr(3, 32'h31);
        wr(0, 2); wr(1, 5);
        idle(2);
        chk("R11 idle level inverted", pulse_out, 1);
        @(negedge clk); trig_in = 1'b1;
        measure(1'b1, d, w, uw);
        chk("R11 inverted delay", d, 5);
        chk("R11 inverted width", w, 4);
        chk("R11 returns high", pulse_out, 1);
        @(negedge clk); trig_in = 1'b0;
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule